// File: doc/BRIEF.md
# Byte-Wide Serial Port Register Front End

This block is the register face of a simple serial port. A host reaches eight byte registers through a 3-bit offset with separate read and write strobes. Behind them sit the divisor bytes, interrupt enable, FIFO control, line control, modem control and scratch registers, a computed line status, a fixed modem status, and a one-byte receive holding register. Incoming bytes arrive as a valid/byte pair. A transmit write leaves the block as a one-cycle strobe with its byte. Baud generation, serial shifting and FIFOs are outside the block. The divisor and FIFO control values are driven out to the neighbours that need them.

The top bit of line control switches offsets 0 and 1 over to the divisor bytes. While that bit is set, every read is refused. Each access returns a registered accept or reject indication one cycle after the strobe. The single level interrupt line rises while transmit interrupts are enabled or received data is waiting. It stays high until a transmit write or a read of pending data clears it. A clearing access always wins over a re-raise in the same cycle.

Top module: `sreg_front`

## Requirements
- R1: After reset the interrupt line is low. The identification register (offset 2) reads 0x01. Line status (offset 5) reads 0x20. Interrupt enable, line control, modem control, scratch, divisor and FIFO control are all 0x00.
- R2: With line-control bit 7 clear, reads behave as follows. Offsets 1, 3, 4 and 7 return the stored interrupt enable, line control, modem control and scratch values. Offset 6 always returns 0x10. Read data appears, and the error flag is low, in the cycle after the read strobe.
- R3: With line-control bit 7 set, writes behave as follows. Offset 0 loads the divisor low byte and offset 1 loads the high byte (`div_o` = {high, low}). Offset 2 loads FIFO control and offset 3 loads line control. A write to offsets 4 to 7 is rejected and changes nothing, and no write in this bank emits a transmit byte.
- R4: With line-control bit 7 set, every read is rejected. The error flag is high and read data is 0x00.
- R5: With line-control bit 7 clear, writes to offsets 5 and 6 are rejected and change nothing.
- R6: An incoming byte is captured only while line-status bit 0 (data ready) is clear, and capturing it sets that bit, so line status reads 0x21. A byte offered while data ready is set is dropped.
- R7: A read at offset 0 with data ready set returns the held byte and clears data ready. The interrupt line is low in the cycle after the read, and the identification register then reads 0x01.
- R8: A read at offset 0 with data ready clear returns 0x00, is accepted, and changes no state.
- R9: A write at offset 0 with line-control bit 7 clear drives `tx_stb` high for one cycle with the byte on `tx_byte`. The interrupt line is low in that same cycle.
- R10: When interrupt-enable bit 1 is set, or data ready is set, the interrupt line rises one cycle later and the identification register reads 0x00. The line stays high after the condition goes away, until a clearing access.
- R11: A clearing access (R7, R9) forces the line low in the following cycle, even when the interrupt condition still holds. The line re-rises one cycle after that.
- R12: Any rejected access raises `bus_err` for exactly one cycle and drives read data to 0x00. A cycle with both strobes high is rejected and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data, valid the cycle after a read |
| bus_err | output | 1 | One-cycle pulse for a rejected access |
| rx_valid | input | 1 | Incoming byte offered |
| rx_byte | input | 8 | Incoming byte |
| tx_stb | output | 1 | One-cycle transmit strobe |
| tx_byte | output | 8 | Transmitted byte |
| irq | output | 1 | Level interrupt line |
| div_o | output | 16 | Divisor {high, low} |
| fifo_ctl_o | output | 8 | FIFO control value |

## Verification
The hardest situation to reach is a clearing access landing while the interrupt condition still holds. In that case the line must dip for exactly one cycle and then come back. The bench sets transmit-interrupt enable, waits for the line, and then issues back-to-back transmit writes, sampling the line right after each write and again one cycle later. A second hard case is the pair of bank-switched offsets. The bench sweeps all eight offsets with both strobes in each bank, and confirms through ordinary reads, made after leaving the bank, that rejected writes left the registers untouched.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

  typedef enum logic [2:0] {
    OFS_DATA    = 3'd0,
    OFS_IEN     = 3'd1,
    OFS_IDENT   = 3'd2,
    OFS_LCTL    = 3'd3,
    OFS_MCTL    = 3'd4,
    OFS_LSTAT   = 3'd5,
    OFS_MSTAT   = 3'd6,
    OFS_SCRATCH = 3'd7
  } ofs_e;

  // one decoded access, at most one load bit set
  typedef struct packed {
    logic rejected;
    logic rd_ok;
    logic rx_rd;
    logic tx_wr;
    logic ld_div_lo;
    logic ld_div_hi;
    logic ld_ien;
    logic ld_fifo;
    logic ld_lctl;
    logic ld_mctl;
    logic ld_scratch;
  } acc_t;

endpackage

// File: rtl/sreg_decode.sv
module sreg_decode
  import sreg_pkg::*;
#(
  parameter int AW = 3
) (
  input  logic [AW-1:0] addr,
  input  logic          rd,
  input  logic          wr,
  input  logic          bank,
  output acc_t          acc
);

  always_comb begin
    acc = '0;
    if (rd && wr) begin
      acc.rejected = 1'b1;
    end else if (wr) begin
      if (bank) begin
        case (ofs_e'(addr))
          OFS_DATA:  acc.ld_div_lo = 1'b1;
          OFS_IEN:   acc.ld_div_hi = 1'b1;
          OFS_IDENT: acc.ld_fifo   = 1'b1;
          OFS_LCTL:  acc.ld_lctl   = 1'b1;
          default:   acc.rejected  = 1'b1;
        endcase
      end else begin
        case (ofs_e'(addr))
          OFS_DATA:    acc.tx_wr      = 1'b1;
          OFS_IEN:     acc.ld_ien     = 1'b1;
          OFS_IDENT:   acc.ld_fifo    = 1'b1;
          OFS_LCTL:    acc.ld_lctl    = 1'b1;
          OFS_MCTL:    acc.ld_mctl    = 1'b1;
          OFS_SCRATCH: acc.ld_scratch = 1'b1;
          default:     acc.rejected   = 1'b1;
        endcase
      end
    end else if (rd) begin
      if (bank) begin
        acc.rejected = 1'b1;
      end else begin
        acc.rd_ok = 1'b1;
        acc.rx_rd = (ofs_e'(addr) == OFS_DATA);
      end
    end
  end

endmodule

// File: rtl/sreg_rx_hold.sv
module sreg_rx_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] in_byte,
  input  logic          drain,
  output logic          ready_o,
  output logic [DW-1:0] byte_o
);

  logic          ready_q;
  logic [DW-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= 1'b0;
      hold_q  <= '0;
    end else if (ready_q) begin
      if (drain) ready_q <= 1'b0;
    end else if (in_valid) begin
      ready_q <= 1'b1;
      hold_q  <= in_byte;
    end
  end

  assign ready_o = ready_q;
  assign byte_o  = hold_q;

  // R6: a held byte is never overwritten
  a_r6_no_overwrite: assert property (@(posedge clk) disable iff (rst)
    ready_q |=> $stable(hold_q));

  // R7: a drain of a held byte empties the holder
  a_r7_drain_clears: assert property (@(posedge clk) disable iff (rst)
    (ready_q && drain) |=> !ready_q);

endmodule

// File: rtl/sreg_irq.sv
module sreg_irq (
  input  logic clk,
  input  logic rst,
  input  logic tx_ien,
  input  logic rx_pend,
  input  logic clear,
  output logic irq_o
);

  logic irq_q;
  logic cond;

  assign cond = tx_ien | rx_pend;

  always_ff @(posedge clk) begin
    if (rst)        irq_q <= 1'b0;
    else if (clear) irq_q <= 1'b0;
    else if (cond)  irq_q <= 1'b1;
  end

  assign irq_o = irq_q;

  // R11: a clearing access wins over re-raising
  a_r11_clear_wins: assert property (@(posedge clk) disable iff (rst)
    clear |=> !irq_o);

  // R10: condition without a clear raises the line
  a_r10_raise: assert property (@(posedge clk) disable iff (rst)
    (cond && !clear) |=> irq_o);

  // R10: line is sticky until cleared
  a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !clear) |=> irq_o);

endmodule

// File: rtl/sreg_front.sv
module sreg_front
  import sreg_pkg::*;
#(
  parameter int          DW        = 8,
  parameter int          AW        = 3,
  parameter logic [7:0]  MSTAT_VAL = 8'h10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_rd,
  input  logic            bus_wr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            bus_err,
  input  logic            rx_valid,
  input  logic [DW-1:0]   rx_byte,
  output logic            tx_stb,
  output logic [DW-1:0]   tx_byte,
  output logic            irq,
  output logic [2*DW-1:0] div_o,
  output logic [DW-1:0]   fifo_ctl_o
);

  localparam int BANK_BIT  = DW - 1;
  localparam int THRE_BIT  = 5;
  localparam int TXIEN_BIT = 1;

  acc_t          acc;
  logic [DW-1:0] div_lo_q, div_hi_q, ien_q, fifo_q, lctl_q, mctl_q, scr_q;
  logic [DW-1:0] rdata_q, tx_byte_q, rd_mux, lstat;
  logic          err_q, tx_stb_q;
  logic          rx_ready;
  logic [DW-1:0] rx_hold;
  logic          irq_w, clear;

  sreg_decode #(.AW(AW)) dec_i (
    .addr (bus_addr),
    .rd   (bus_rd),
    .wr   (bus_wr),
    .bank (lctl_q[BANK_BIT]),
    .acc  (acc)
  );

  sreg_rx_hold #(.DW(DW)) rx_i (
    .clk      (clk),
    .rst      (rst),
    .in_valid (rx_valid),
    .in_byte  (rx_byte),
    .drain    (acc.rx_rd),
    .ready_o  (rx_ready),
    .byte_o   (rx_hold)
  );

  assign clear = acc.tx_wr | (acc.rx_rd & rx_ready);

  sreg_irq irq_i (
    .clk     (clk),
    .rst     (rst),
    .tx_ien  (ien_q[TXIEN_BIT]),
    .rx_pend (rx_ready),
    .clear   (clear),
    .irq_o   (irq_w)
  );

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      div_lo_q <= '0;
      div_hi_q <= '0;
      ien_q    <= '0;
      fifo_q   <= '0;
      lctl_q   <= '0;
      mctl_q   <= '0;
      scr_q    <= '0;
    end else begin
      if (acc.ld_div_lo)  div_lo_q <= bus_wdata;
      if (acc.ld_div_hi)  div_hi_q <= bus_wdata;
      if (acc.ld_ien)     ien_q    <= bus_wdata;
      if (acc.ld_fifo)    fifo_q   <= bus_wdata;
      if (acc.ld_lctl)    lctl_q   <= bus_wdata;
      if (acc.ld_mctl)    mctl_q   <= bus_wdata;
      if (acc.ld_scratch) scr_q    <= bus_wdata;
    end
  end

  always_comb begin
    lstat           = '0;
    lstat[THRE_BIT] = 1'b1;
    lstat[0]        = rx_ready;
  end

  always_comb begin
    case (ofs_e'(bus_addr))
      OFS_DATA:    rd_mux = rx_ready ? rx_hold : '0;
      OFS_IEN:     rd_mux = ien_q;
      OFS_IDENT:   rd_mux = DW'(!irq_w);
      OFS_LCTL:    rd_mux = lctl_q;
      OFS_MCTL:    rd_mux = mctl_q;
      OFS_LSTAT:   rd_mux = lstat;
      OFS_MSTAT:   rd_mux = DW'(MSTAT_VAL);
      default:     rd_mux = scr_q;
    endcase
  end

  // registered bus and transmit outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q   <= '0;
      err_q     <= 1'b0;
      tx_stb_q  <= 1'b0;
      tx_byte_q <= '0;
    end else begin
      rdata_q  <= acc.rd_ok ? rd_mux : '0;
      err_q    <= acc.rejected;
      tx_stb_q <= acc.tx_wr;
      if (acc.tx_wr) tx_byte_q <= bus_wdata;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_err    = err_q;
  assign tx_stb     = tx_stb_q;
  assign tx_byte    = tx_byte_q;
  assign irq        = irq_w;
  assign div_o      = {div_hi_q, div_lo_q};
  assign fifo_ctl_o = fifo_q;

  // R4: any read in the divisor bank is refused with zero data
  a_r4_bank_read_rejected: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr && lctl_q[BANK_BIT]) |=> (bus_err && bus_rdata == '0));

  // R9: a transmit strobe comes with the line low
  a_r9_tx_drops_irq: assert property (@(posedge clk) disable iff (rst)
    tx_stb |-> !irq);

  // R12: a rejected access emits nothing and returns zero
  a_r12_err_quiet: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> (!tx_stb && bus_rdata == '0));

  // R12: simultaneous strobes leave the configuration unchanged
  a_r12_both_strobes: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_wr) |=> ($stable(scr_q) && $stable(lctl_q) && bus_err));

endmodule

// File: tb/sreg_front_tb.sv
module sreg_front_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] bus_addr = '0;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       bus_err;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_byte = '0;
  logic       tx_stb;
  logic [7:0] tx_byte;
  logic       irq;
  logic [15:0] div_o;
  logic [7:0] fifo_ctl_o;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] s_rd;
  logic       s_err, s_tx;
  logic [7:0] s_txb;

  always #2.5 clk = ~clk;

  sreg_front dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_stb(tx_stb), .tx_byte(tx_byte),
    .irq(irq), .div_o(div_o), .fifo_ctl_o(fifo_ctl_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sample();
    s_rd = bus_rdata; s_err = bus_err; s_tx = tx_stb; s_txb = tx_byte;
  endtask

  task automatic acc(input logic r, input logic w, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = r; bus_wr = w; bus_wdata = d;
    @(posedge clk); #1;
    sample();
    bus_rd = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d); acc(1'b0, 1'b1, a, d); endtask
  task automatic rd(input logic [2:0] a); acc(1'b1, 1'b0, a, 8'h00); endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic rx_push(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = b;
    @(posedge clk); #1;
    rx_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    idle(1);

    // R1 reset state
    check("R1 irq", irq, 0);
    check("R1 err", bus_err, 0);
    check("R1 div", div_o, 16'h0000);
    check("R1 fifo", fifo_ctl_o, 0);
    rd(3'd2); check("R1 ident", s_rd, 8'h01);
    rd(3'd5); check("R1 lstat", s_rd, 8'h20);
    rd(3'd1); check("R1 ien", s_rd, 0);
    rd(3'd3); check("R1 lctl", s_rd, 0);
    rd(3'd4); check("R1 mctl", s_rd, 0);
    rd(3'd7); check("R1 scratch", s_rd, 0);

    // R2 read map sweep
    for (int v = 0; v < 256; v++) begin
      wr(3'd7, v[7:0]);
      wr(3'd4, v[7:0] ^ 8'h5A);
      rd(3'd7); check("R2 scratch", {s_err, s_rd}, {1'b0, v[7:0]});
      rd(3'd4); check("R2 mctl", s_rd, v[7:0] ^ 8'h5A);
    end
    for (int v = 0; v < 256; v += 17) begin
      wr(3'd1, v[7:0] & 8'hFD);
      rd(3'd1); check("R2 ien", s_rd, v[7:0] & 8'hFD);
    end
    wr(3'd1, 8'h00);
    rd(3'd6); check("R2 mstat", s_rd, 8'h10);
    check("R10 no irq without cond", irq, 0);

    // R5 rejected writes outside the bank, R12 error pulse
    for (int a = 5; a <= 6; a++) begin
      wr(a[2:0], 8'hFF); check("R5 reject", s_err, 1);
      check("R12 err zero data", s_rd, 0);
      idle(1); check("R12 err one cycle", bus_err, 0);
    end
    rd(3'd5); check("R5 lstat untouched", s_rd, 8'h20);
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0]); check("R2 read accepted", s_err, 0);
    end

    // R3 divisor bank
    wr(3'd7, 8'hA5); wr(3'd4, 8'h3C);
    wr(3'd3, 8'h83);
    wr(3'd0, 8'h34); check("R3 no tx in bank", s_tx, 0);
    wr(3'd1, 8'h12);
    idle(1); check("R3 divisor", div_o, 16'h1234);
    wr(3'd2, 8'hC7); check("R3 fifo", fifo_ctl_o, 8'hC7);
    for (int a = 4; a < 8; a++) begin
      wr(a[2:0], 8'h00); check("R3 bank write reject", s_err, 1);
    end
    // R4 every read rejected in bank
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0]); check("R4 bank read err", s_err, 1);
      check("R4 bank read zero", s_rd, 0);
    end
    wr(3'd3, 8'h03); check("R3 lctl in bank", s_err, 0);
    rd(3'd3); check("R3 lctl", s_rd, 8'h03);
    rd(3'd4); check("R3 mctl untouched", s_rd, 8'h3C);
    rd(3'd7); check("R3 scratch untouched", s_rd, 8'hA5);
    rd(3'd1); check("R3 ien untouched", s_rd, 8'h00);
    check("R3 divisor kept", div_o, 16'h1234);

    // R12 both strobes
    acc(1'b1, 1'b1, 3'd7, 8'hEE); check("R12 both err", s_err, 1);
    check("R12 both no tx", s_tx, 0);
    rd(3'd7); check("R12 both no write", s_rd, 8'hA5);

    // R6..R8 receive path
    for (int k = 0; k < 256; k += 37) begin
      rx_push(k[7:0]);
      rd(3'd5); check("R6 data ready", s_rd, 8'h21);
      check("R10 irq on rx", irq, 1);
      rd(3'd2); check("R10 ident pending", s_rd, 8'h00);
      rx_push(~k[7:0]);
      rd(3'd0); check("R7 held byte", s_rd, k[7:0]);
      check("R7 irq dropped", irq, 0);
      rd(3'd2); check("R7 ident clear", s_rd, 8'h01);
      rd(3'd5); check("R7 ready cleared", s_rd, 8'h20);
      rd(3'd0); check("R8 empty read", {s_err, s_rd}, 9'h000);
      rd(3'd5); check("R8 no state change", s_rd, 8'h20);
      check("R8 irq stays low", irq, 0);
    end

    // R9..R11 transmit path
    wr(3'd1, 8'h02);
    idle(1); check("R10 irq on tx enable", irq, 1);
    for (int k = 1; k < 256; k += 51) begin
      wr(3'd0, k[7:0]);
      check("R9 tx strobe", s_tx, 1);
      check("R9 tx byte", s_txb, k[7:0]);
      check("R11 low after clear", irq, 0);
      idle(1); check("R9 strobe one cycle", tx_stb, 0);
      check("R11 re-rise", irq, 1);
    end
    wr(3'd0, 8'h11); wr(3'd0, 8'h22);
    check("R11 back to back", irq, 0);
    check("R9 second byte", s_txb, 8'h22);
    idle(1); check("R11 re-rise after pair", irq, 1);
    wr(3'd1, 8'h00);
    idle(2); check("R10 sticky", irq, 1);
    wr(3'd0, 8'h33); idle(2);
    check("R10 stays low", irq, 0);
    rd(3'd2); check("R10 ident idle", s_rd, 8'h01);

    finish_run();
  end

endmodule